// File: doc/BRIEF.md
# Quad-Phased Split Address/Data Bus Sequencer

This block sequences a synchronous system bus with separate address and data paths. Bus time runs in quads of four states. The address quad of a transaction has four cycles, always in this order: arbitration, I/O, real address and virtual address. The data quad of the same transaction follows a fixed number of quads later. Several local requesters present transaction attributes. In each arbitration cycle one requester wins by rotating priority. The sequencer then drives the remaining three address cycles from the winner's latched attributes. It launches the matching data beats on a 64-bit data path exactly when the transaction's data quad arrives.

Non-DMA I/O transactions carry their data on the address bus during the I/O cycle, so they never occupy a data quad. A short in-order pipeline of pending transactions keeps one record per quad: validity, direction, size and owner. Because of this, new address quads overlap with the data quads of earlier transactions. Block sizes of 16 and 32 bytes are carried. A 64-byte request cannot be carried on the 64-bit path, so it is flagged as an error.

Top module: `qbus_ctrl`

## Requirements
- R1: `a_phase` steps 0,1,2,3 and then repeats. The codes are 0 = arbitration, 1 = I/O, 2 = real address, 3 = virtual address. The first cycle after reset is phase 0.
- R2: A synchronous active-high reset leaves the bus idle at phase 0, with `gnt`, `a_vld`, `size_err` and `d_vld` low and no data quads pending.
- R3: `gnt` is non-zero only in phase 0. It is one-hot, it goes only to a requester whose `req_vld` bit is set, and it is zero when no request is present.
- R4: Priority rotates. The grant goes to the first requesting index at or after a pointer, searching upward and wrapping. The pointer starts at 0 after reset and moves to one past the winner after every grant.
- R5: After a valid grant, `a_vld` is high in phases 1 to 3 of that quad and `a_owner` is the winner's index. `a_bus` carries the winner's `req_iod` in phase 1 for an I/O request, or zero for a DMA request. It carries `req_ra` in phase 2 and `req_va` in phase 3, all sampled in the arbitration cycle.
- R6: Size codes are 0 = 16 bytes, 1 = 32 bytes, 2 or 3 = 64 bytes (unsupported). A DMA winner with code 2 or 3 raises `size_err` with its grant. `a_vld` then stays low for that quad and no data quad is produced. The pointer still rotates.
- R7: The data quad of a DMA transaction starts exactly 4*LAT_QUADS cycles after the arbitration cycle of its address quad. For a 32-byte block it asserts `d_vld` with `d_beat` 0,1,2,3 on consecutive cycles, and `d_owner` and `d_wr` come from that transaction.
- R8: A 16-byte block asserts `d_vld` only for beats 0 and 1, and beats 2 and 3 stay idle.
- R9: `req_io` = 1 marks a non-DMA I/O transaction. It produces no data quad, and its size code is ignored.
- R10: Address quads continue every quad while up to LAT_QUADS earlier data quads are pending. Pending transactions complete in the order they were granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | NREQ | Request present, one bit per requester |
| req_io | input | NREQ | 1 = non-DMA I/O transaction |
| req_wr | input | NREQ | 1 = write, 0 = read |
| req_size | input | 2*NREQ | Block size code per requester |
| req_ra | input | NREQ*AW | Real address per requester |
| req_va | input | NREQ*AW | Virtual address per requester |
| req_iod | input | NREQ*AW | I/O data per requester |
| gnt | output | NREQ | One-hot grant in the arbitration cycle |
| size_err | output | 1 | Unsupported block size on the granted request |
| a_phase | output | 2 | Current address-quad cycle code |
| a_vld | output | 1 | Address bus carries a valid field |
| a_bus | output | AW | Address bus field value |
| a_owner | output | 4 | Owner of the current address quad |
| d_vld | output | 1 | Data beat active |
| d_beat | output | 2 | Beat number within the data quad |
| d_owner | output | 4 | Owner of the active data quad |
| d_wr | output | 1 | Active data quad is a write |

## Verification
The first pattern keeps all requesters asserted with 32-byte DMA requests. This separates a correct rotating pointer from a fixed-priority one, and it shows full four-beat data quads overlapping later address quads. A lone requester with 16-byte blocks shows that beats 2 and 3 stay idle and that the pointer wraps past empty slots. Mixes of 64-byte and I/O requests show the difference between an erroring quad, which has no address fields and no data, and an I/O quad, which has address fields but no data. Long random traffic then checks every output against a cycle model on every cycle.

// File: rtl/qbus_pkg.sv
package qbus_pkg;
    // widest requester index carried on the bus (up to 16 requesters)
    localparam int IDW = 4;

    typedef enum logic [1:0] {
        PH_ARB  = 2'd0,
        PH_IO   = 2'd1,
        PH_REAL = 2'd2,
        PH_VIRT = 2'd3
    } phase_e;

    // one pending data-quad record
    typedef struct packed {
        logic           vld;
        logic           wr;
        logic           sz32;
        logic [IDW-1:0] own;
    } dq_ent_t;
endpackage

// File: rtl/qbus_rr_arb.sv
module qbus_rr_arb
    import qbus_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   req,
    input  logic           adv,
    output logic [N-1:0]   gnt,
    output logic [IDW-1:0] win,
    output logic           any
);
    typedef struct packed {
        logic [IDW-1:0] ptr;
    } arb_t;

    arb_t st_d, st_q;

    always_comb begin
        logic [N-1:0] rot;
        int           idx;
        st_d = st_q;
        any  = 1'b0;
        win  = '0;
        for (int i = 0; i < N; i++) begin
            idx = (int'(st_q.ptr) + i) % N;
            rot = req >> idx;
            if (!any && rot[0]) begin
                any = 1'b1;
                win = IDW'(idx);
            end
        end
        for (int i = 0; i < N; i++) begin
            gnt[i] = adv && any && (win == IDW'(i));
        end
        if (adv && any) begin
            st_d.ptr = (win == IDW'(N - 1)) ? '0 : win + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3
    gnt_req_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);
endmodule

// File: rtl/qbus_dpipe.sv
module qbus_dpipe
    import qbus_pkg::*;
#(
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     phase,
    input  logic           push,
    input  dq_ent_t        ent,
    output logic           d_vld,
    output logic [1:0]     d_beat,
    output logic [IDW-1:0] d_owner,
    output logic           d_wr
);
    dq_ent_t pipe_d [LAT];
    dq_ent_t pipe_q [LAT];
    dq_ent_t cur;

    always_comb begin
        for (int k = 0; k < LAT; k++) pipe_d[k] = pipe_q[k];
        if (push) begin
            pipe_d[0] = ent;
            for (int k = 1; k < LAT; k++) pipe_d[k] = pipe_q[k-1];
        end
        cur     = pipe_q[LAT-1];
        d_vld   = cur.vld && (cur.sz32 || !phase[1]);
        d_beat  = phase;
        d_owner = cur.own;
        d_wr    = cur.wr;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < LAT; k++) begin
            if (rst) pipe_q[k] <= '0;
            else     pipe_q[k] <= pipe_d[k];
        end
    end

    // R10
    push_edge_chk: assert property (@(posedge clk) disable iff (rst)
        push |-> (phase == 2'd3));
endmodule

// File: rtl/qbus_ctrl.sv
module qbus_ctrl
    import qbus_pkg::*;
#(
    parameter int NREQ      = 4,
    parameter int AW        = 32,
    parameter int LAT_QUADS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NREQ-1:0]      req_vld,
    input  logic [NREQ-1:0]      req_io,
    input  logic [NREQ-1:0]      req_wr,
    input  logic [2*NREQ-1:0]    req_size,
    input  logic [NREQ*AW-1:0]   req_ra,
    input  logic [NREQ*AW-1:0]   req_va,
    input  logic [NREQ*AW-1:0]   req_iod,
    output logic [NREQ-1:0]      gnt,
    output logic                 size_err,
    output logic [1:0]           a_phase,
    output logic                 a_vld,
    output logic [AW-1:0]        a_bus,
    output logic [IDW-1:0]       a_owner,
    output logic                 d_vld,
    output logic [1:0]           d_beat,
    output logic [IDW-1:0]       d_owner,
    output logic                 d_wr
);
    typedef struct packed {
        phase_e         ph;
        logic [IDW-1:0] own;
        logic           io;
        logic           wr;
        logic           sz32;
        logic           ok;
        logic [AW-1:0]  ra;
        logic [AW-1:0]  va;
        logic [AW-1:0]  iod;
    } ctl_t;

    ctl_t           st_d, st_q;
    logic           arb_cyc;
    logic [IDW-1:0] win;
    logic           any;
    logic           push;
    dq_ent_t        ent;

    assign arb_cyc = (st_q.ph == PH_ARB);

    qbus_rr_arb #(.N(NREQ)) i_arb (
        .clk (clk),
        .rst (rst),
        .req (req_vld),
        .adv (arb_cyc),
        .gnt (gnt),
        .win (win),
        .any (any)
    );

    always_comb begin
        logic          w_io, w_wr;
        logic [1:0]    w_sz;
        logic [AW-1:0] w_ra, w_va, w_iod;
        w_io = 1'b0; w_wr = 1'b0; w_sz = '0;
        w_ra = '0;   w_va = '0;   w_iod = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (gnt[i]) begin
                w_io  = req_io[i];
                w_wr  = req_wr[i];
                w_sz  = req_size[2*i +: 2];
                w_ra  = req_ra[i*AW +: AW];
                w_va  = req_va[i*AW +: AW];
                w_iod = req_iod[i*AW +: AW];
            end
        end
        size_err = arb_cyc && any && !w_io && w_sz[1];

        st_d    = st_q;
        st_d.ph = phase_e'(st_q.ph + 2'd1);
        if (arb_cyc) begin
            st_d.ok   = any && !size_err;
            st_d.own  = win;
            st_d.io   = w_io;
            st_d.wr   = w_wr;
            st_d.sz32 = w_sz[0];
            st_d.ra   = w_ra;
            st_d.va   = w_va;
            st_d.iod  = w_iod;
        end

        a_phase = st_q.ph;
        a_owner = st_q.own;
        a_vld   = st_q.ok && !arb_cyc;
        unique case (st_q.ph)
            PH_IO:   a_bus = st_q.io ? st_q.iod : '0;
            PH_REAL: a_bus = st_q.ra;
            PH_VIRT: a_bus = st_q.va;
            default: a_bus = '0;
        endcase
        if (!a_vld) a_bus = '0;

        push     = (st_q.ph == PH_VIRT);
        ent.vld  = st_q.ok && !st_q.io;
        ent.wr   = st_q.wr;
        ent.sz32 = st_q.sz32;
        ent.own  = st_q.own;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    qbus_dpipe #(.LAT(LAT_QUADS)) i_dpipe (
        .clk     (clk),
        .rst     (rst),
        .phase   (st_q.ph),
        .push    (push),
        .ent     (ent),
        .d_vld   (d_vld),
        .d_beat  (d_beat),
        .d_owner (d_owner),
        .d_wr    (d_wr)
    );

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (a_phase == 2'd3) |=> (a_phase == 2'd0));
    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        (a_phase != 2'd3) |=> (a_phase == $past(a_phase) + 2'd1));
    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt) && ((gnt == '0) || (a_phase == 2'd0)));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (a_vld && a_phase == 2'd2) |=> (a_vld && $stable(a_owner)));
    // R6
    err_noaddr_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |=> !a_vld);
    // R7
    beat_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (d_vld && d_beat == 2'd0) |=> (d_vld && d_beat == 2'd1 && $stable(d_owner)));
    // R8
    beat_tail_chk: assert property (@(posedge clk) disable iff (rst)
        (d_vld && d_beat == 2'd2) |=> (d_vld && d_beat == 2'd3));
endmodule

// File: tb/test_qbus_ctrl.sv
module test_qbus_ctrl;
    localparam int NREQ = 4;
    localparam int AW   = 32;
    localparam int LAT  = 2;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NREQ-1:0]     req_vld = '0, req_io = '0, req_wr = '0;
    logic [2*NREQ-1:0]   req_size = '0;
    logic [NREQ*AW-1:0]  req_ra = '0, req_va = '0, req_iod = '0;
    logic [NREQ-1:0]     gnt;
    logic                size_err, a_vld, d_vld, d_wr;
    logic [1:0]          a_phase, d_beat;
    logic [AW-1:0]       a_bus;
    logic [3:0]          a_owner, d_owner;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    qbus_ctrl #(.NREQ(NREQ), .AW(AW), .LAT_QUADS(LAT)) i_qbus_ctrl (
        .clk(clk), .rst(rst), .req_vld(req_vld), .req_io(req_io),
        .req_wr(req_wr), .req_size(req_size), .req_ra(req_ra),
        .req_va(req_va), .req_iod(req_iod), .gnt(gnt), .size_err(size_err),
        .a_phase(a_phase), .a_vld(a_vld), .a_bus(a_bus), .a_owner(a_owner),
        .d_vld(d_vld), .d_beat(d_beat), .d_owner(d_owner), .d_wr(d_wr));

    // cycle model state
    int m_ph = 0, m_ptr = 0, m_own = 0;
    bit m_ok = 0, m_io = 0, m_wr = 0, m_32 = 0;
    logic [AW-1:0] m_ra = '0, m_va = '0, m_iod = '0;
    bit p_v [LAT], p_wr [LAT], p_32 [LAT];
    int p_own [LAT];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int pick_winner(input logic [NREQ-1:0] v, input int ptr);
        for (int i = 0; i < NREQ; i++) begin
            if (v[(ptr + i) % NREQ]) return (ptr + i) % NREQ;
        end
        return -1;
    endfunction

    function automatic logic [AW-1:0] exp_abus();
        if (!(m_ok && m_ph != 0)) return '0;
        if (m_ph == 1) return m_io ? m_iod : '0;
        if (m_ph == 2) return m_ra;
        return m_va;
    endfunction

    // compare all outputs with the model, then advance the model one cycle
    task automatic step_check();
        int  w;
        bit  e_err, e_av, e_dv;
        logic [NREQ-1:0] e_g;
        w = (m_ph == 0) ? pick_winner(req_vld, m_ptr) : -1;
        e_g = (w >= 0) ? (NREQ'(1) << w) : '0;
        e_err = (w >= 0) && !req_io[w] && req_size[2*w+1];
        e_av = m_ok && (m_ph != 0);
        e_dv = p_v[LAT-1] && (p_32[LAT-1] || m_ph < 2);
        chk(a_phase == 2'(m_ph), "R1 phase", a_phase, m_ph);
        chk(gnt == e_g, "R3/R4 grant", gnt, e_g);
        chk(size_err == e_err, "R6 size_err", size_err, e_err);
        chk(a_vld == e_av, "R5/R6 a_vld", a_vld, e_av);
        chk(a_bus == exp_abus(), "R5 a_bus", a_bus, exp_abus());
        if (e_av) chk(a_owner == 4'(m_own), "R5 a_owner", a_owner, m_own);
        chk(d_vld == e_dv, "R7/R8/R9 d_vld", d_vld, e_dv);
        if (e_dv) begin
            chk(d_beat == 2'(m_ph), "R7 d_beat", d_beat, m_ph);
            chk(d_owner == 4'(p_own[LAT-1]), "R10 d_owner", d_owner, p_own[LAT-1]);
            chk(d_wr == p_wr[LAT-1], "R10 d_wr", d_wr, p_wr[LAT-1]);
        end
        if (m_ph == 3) begin
            for (int k = LAT - 1; k > 0; k--) begin
                p_v[k] = p_v[k-1]; p_wr[k] = p_wr[k-1];
                p_32[k] = p_32[k-1]; p_own[k] = p_own[k-1];
            end
            p_v[0] = m_ok && !m_io; p_wr[0] = m_wr; p_32[0] = m_32; p_own[0] = m_own;
        end
        if (m_ph == 0) begin
            m_ok = (w >= 0) && !e_err;
            if (w >= 0) begin
                m_ptr = (w + 1) % NREQ;
                m_own = w; m_io = req_io[w]; m_wr = req_wr[w];
                m_32 = req_size[2*w]; m_ra = req_ra[w*AW +: AW];
                m_va = req_va[w*AW +: AW]; m_iod = req_iod[w*AW +: AW];
            end
        end
        m_ph = (m_ph + 1) % 4;
    endtask

    // seg: 0 idle, 1 all 32B DMA, 2 lone 16B, 3 64B mix, 4 I/O mix, else random
    task automatic drive(input int seg);
        for (int i = 0; i < NREQ; i++) begin
            req_ra[i*AW +: AW]  = $urandom;
            req_va[i*AW +: AW]  = $urandom;
            req_iod[i*AW +: AW] = $urandom;
            req_wr[i]           = 1'($urandom);
            case (seg)
                0: begin req_vld[i] = 0; req_io[i] = 0; req_size[2*i +: 2] = 2'd1; end
                1: begin req_vld[i] = 1; req_io[i] = 0; req_size[2*i +: 2] = 2'd1; end
                2: begin req_vld[i] = (i == 2); req_io[i] = 0; req_size[2*i +: 2] = 2'd0; end
                3: begin req_vld[i] = 1; req_io[i] = 0; req_size[2*i +: 2] = (i % 2 == 1) ? 2'(2 + (i / 2)) : 2'd1; end
                4: begin req_vld[i] = 1'($urandom); req_io[i] = 1; req_size[2*i +: 2] = 2'($urandom); end
                default: begin
                    req_vld[i] = ($urandom % 3) != 0;
                    req_io[i]  = ($urandom % 4) == 0;
                    req_size[2*i +: 2] = 2'($urandom);
                end
            endcase
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < LAT; k++) begin p_v[k] = 0; p_wr[k] = 0; p_32[k] = 0; p_own[k] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2 reset state
        chk(a_phase == 2'd0, "R2 phase", a_phase, 0);
        chk(!a_vld && !d_vld && !size_err && gnt == '0, "R2 idle", {a_vld, d_vld, size_err, gnt}, 0);
        for (int c = 0; c < 3000; c++) begin
            if (c > 0) @(negedge clk);
            drive(c < 400 ? c / 80 : 9);
            #1;
            step_check();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule